// File: doc/BRIEF.md
# Pruned Row-Column Turbo Interleaver Address Generator

This block produces the read-address sequence of a turbo-code interleaver for a codeword length L that can be set for each block. It sizes a power-of-two mother permutation at or above L. It treats that permutation as a grid of 32 rows and a power-of-two number of columns. Each row is scrambled by its own additive congruential sequence, the row order is bit-reversed, and the grid is scanned column by column. A candidate address that falls at or above L is dropped. The block therefore emits exactly L addresses, and they form a permutation of 0..L-1.

A controller waits for `ready`, presents L on `len_in` and pulses `start`. The generator then walks every mother-grid position at one position per clock. It raises `addr_valid` only for positions that survive pruning. It pulses `done` together with the last position and returns to idle. The control is a three-state machine:

- IDLE: ready is high.
- SETUP: the mother size is derived from the latched length.
- RUN: the grid is scanned.

The transitions are:

- accept: IDLE to SETUP, on a start with a legal length.
- reject: IDLE stays in IDLE, on a start with an illegal length.
- arm: SETUP to RUN, always after one cycle.
- finish: RUN to IDLE, on the last grid position.

Top module: `prune_ilv_agen`

## Requirements
- R1: After reset, `ready` is 1 and `addr_valid` and `done` are 0.
- R2: A `start` pulse seen while `ready` is 1 with 1 <= `len_in` <= 4096 is accepted, and `ready` is 0 in the following cycle.
- R3: A `start` with `len_in` equal to 0 or above 4096 is ignored: `ready` stays 1, and neither `addr_valid` nor `done` is raised.
- R4: The mother size is M = 2^n, where n is the smallest value in 6..12 with L <= 2^n. The grid has 32 rows and K = 2^(n-5) columns.
- R5: The row step of row i is c_i = (2*((13*i + 5) mod 64) + 1) mod K. The permuted column of row i at column j is s_i(j) = (j * c_i) mod K, so s_i(0) = 0 and each step adds c_i modulo K.
- R6: Position (j, i) maps to candidate bitrev5(i)*K + s_i(j), where bitrev5 mirrors the 5-bit row index (bit 0 to bit 4). Positions are visited with j as the outer loop (0..K-1) and i as the inner loop (0..31).
- R7: A candidate at or above L is pruned: `addr_valid` stays 0 in that cycle, and every address shown with `addr_valid` is below L.
- R8: One job produces exactly L valid addresses. Together they form a permutation of 0..L-1, in the order R6 defines.
- R9: The candidate for the first grid position appears 2 cycles after the accepting edge, with one position per cycle after that. `done` is a single-cycle pulse in the cycle of the last position (M+1 cycles after acceptance), and `ready` is 1 in that same cycle.
- R10: A `start` pulse while `ready` is 0 is ignored, and the running job's sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job request strobe, taken only while ready is 1 |
| len_in | input | 13 | Codeword length L, legal range 1..4096 |
| ready | output | 1 | Generator idle and able to accept a job |
| addr_out | output | 12 | Interleaved address, meaningful when addr_valid is 1 |
| addr_valid | output | 1 | addr_out holds a surviving (unpruned) address |
| done | output | 1 | One-cycle pulse on the last grid position of a job |

## Verification
The bound checker watches several properties on every cycle:

- Each valid address is below the latched length.
- `ready` falls after an accepted start and stays high after a rejected one.
- `done` lasts exactly one cycle.
- The number of valid pulses equals L when `done` fires.
- Nothing valid appears while the block is idle.

Other behaviours only the bench scenarios can show. These are the exact ordering given by the row steps and the bit-reversed rows, the fact that the L outputs cover 0..L-1 with no repeats, and the cycle count of each job. The bench shows them by sweeping lengths across every mother size and their boundaries. It also shows that a job is not disturbed by a start pulse in mid-run.

// File: rtl/prune_ilv_pkg.sv
package prune_ilv_pkg;

    localparam int ROW_LOG = 5;
    localparam int MIN_LOG = 6;
    localparam int MAX_LOG = 12;
    localparam int ROWS    = 1 << ROW_LOG;
    localparam int COL_LOG = MAX_LOG - ROW_LOG;
    localparam int LEN_W   = MAX_LOG + 1;
    localparam int N_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } agen_state_t;

    // Odd row step for row k, kept to the widest column count.
    function automatic logic [COL_LOG-1:0] row_step(input int k);
        int v;
        v = 2 * ((13 * k + 5) % 64) + 1;
        return COL_LOG'(v);
    endfunction

endpackage

// File: rtl/ilv_len_decode.sv
module ilv_len_decode
    import prune_ilv_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic [N_W-1:0]   n_log
);
    always_comb begin
        n_log = N_W'(MAX_LOG);
        for (int k = MAX_LOG; k >= MIN_LOG; k--) begin
            if (32'(len) <= (32'd1 << k)) begin
                n_log = N_W'(k);
            end
        end
    end
endmodule

// File: rtl/ilv_step_rom.sv
module ilv_step_rom
    import prune_ilv_pkg::*;
(
    input  logic [ROW_LOG-1:0] row,
    output logic [COL_LOG-1:0] step
);
    logic [COL_LOG-1:0] table_q [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_entry
        assign table_q[g] = row_step(g);
    end

    assign step = table_q[row];
endmodule

// File: rtl/ilv_cand_gen.sv
module ilv_cand_gen
    import prune_ilv_pkg::*;
(
    input  logic [ROW_LOG-1:0] row,
    input  logic [COL_LOG-1:0] col,
    input  logic [COL_LOG-1:0] step,
    input  logic [N_W-1:0]     n_log,
    input  logic [COL_LOG-1:0] col_mask,
    output logic [MAX_LOG-1:0] cand
);
    logic [ROW_LOG-1:0]   row_rev;
    logic [2*COL_LOG-1:0] prod;
    logic [COL_LOG-1:0]   perm;
    logic [MAX_LOG-1:0]   base;
    logic [N_W-1:0]       shift;

    for (genvar b = 0; b < ROW_LOG; b++) begin : g_rev
        assign row_rev[b] = row[ROW_LOG-1-b];
    end

    always_comb begin
        prod  = {{COL_LOG{1'b0}}, col} * {{COL_LOG{1'b0}}, step};
        perm  = prod[COL_LOG-1:0] & col_mask;
        shift = n_log - N_W'(ROW_LOG);
        base  = {{(MAX_LOG-ROW_LOG){1'b0}}, row_rev} << shift;
        cand  = base | {{(MAX_LOG-COL_LOG){1'b0}}, perm};
    end
endmodule

// File: rtl/prune_ilv_agen.sv
module prune_ilv_agen
    import prune_ilv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   len_in,
    output logic               ready,
    output logic [MAX_LOG-1:0] addr_out,
    output logic               addr_valid,
    output logic               done
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1 << MAX_LOG);

    agen_state_t        state_q, state_d;
    logic [LEN_W-1:0]   len_q;
    logic [N_W-1:0]     n_q;
    logic [N_W-1:0]     n_dec;
    logic [ROW_LOG-1:0] row_q;
    logic [COL_LOG-1:0] col_q;
    logic [COL_LOG-1:0] col_mask;
    logic [COL_LOG-1:0] step;
    logic [MAX_LOG-1:0] cand;
    logic               len_ok;
    logic               last_pos;
    logic               accept;

    ilv_len_decode u_dec (
        .len   (len_q),
        .n_log (n_dec)
    );

    ilv_step_rom u_rom (
        .row  (row_q),
        .step (step)
    );

    ilv_cand_gen u_cand (
        .row      (row_q),
        .col      (col_q),
        .step     (step),
        .n_log    (n_q),
        .col_mask (col_mask),
        .cand     (cand)
    );

    always_comb begin
        len_ok   = (len_in != '0) && (len_in <= MAX_LEN);
        accept   = (state_q == ST_IDLE) && start && len_ok;
        col_mask = COL_LOG'((8'd1 << (n_q - N_W'(ROW_LOG))) - 8'd1);
        last_pos = (row_q == ROW_LOG'(ROWS - 1)) && (col_q == col_mask);
        ready    = (state_q == ST_IDLE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SETUP;      // accept / reject
            ST_SETUP: state_d = ST_RUN;                    // arm
            ST_RUN:   if (last_pos) state_d = ST_IDLE;     // finish
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q      <= '0;
            n_q        <= N_W'(MIN_LOG);
            row_q      <= '0;
            col_q      <= '0;
            addr_out   <= '0;
            addr_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            addr_valid <= 1'b0;
            done       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) len_q <= len_in;
                end
                ST_SETUP: begin
                    n_q   <= n_dec;
                    row_q <= '0;
                    col_q <= '0;
                end
                ST_RUN: begin
                    addr_out   <= cand;
                    addr_valid <= ({1'b0, cand} < len_q);
                    done       <= last_pos;
                    row_q      <= row_q + 1'b1;
                    if (row_q == ROW_LOG'(ROWS - 1)) col_q <= col_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/prune_ilv_agen_chk.sv
module prune_ilv_agen_chk
    import prune_ilv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LEN_W-1:0]   len_in,
    input logic               ready,
    input logic [MAX_LOG-1:0] addr_out,
    input logic               addr_valid,
    input logic               done
);
    logic [LEN_W-1:0] len_c;
    logic [LEN_W-1:0] cnt_c;
    logic             good_len;

    assign good_len = (len_in != '0) && (len_in <= LEN_W'(1 << MAX_LOG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_c <= '0;
            cnt_c <= '0;
        end else if (start && ready && good_len) begin
            len_c <= len_in;
            cnt_c <= '0;
        end else if (addr_valid) begin
            cnt_c <= cnt_c + 1'b1;
        end
    end

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && good_len) |=> !ready);

    assert_bad_len_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && !good_len && !done) |=> (ready && !addr_valid && !done));

    assert_valid_below_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ({1'b0, addr_out} < len_c));

    assert_count_matches_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cnt_c + LEN_W'(addr_valid)) == len_c));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !done) |-> !addr_valid);
endmodule

bind prune_ilv_agen prune_ilv_agen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_in     (len_in),
    .ready      (ready),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .done       (done)
);

// File: tb/prune_ilv_agen_test.sv
module prune_ilv_agen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] len_in = '0;
    logic        ready;
    logic [11:0] addr_out;
    logic        addr_valid;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    int exp_addr [4096];
    bit seen     [4096];

    always #2 clk = ~clk;

    prune_ilv_agen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len_in     (len_in),
        .ready      (ready),
        .addr_out   (addr_out),
        .addr_valid (addr_valid),
        .done       (done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mother_log(input int l);
        int n = 12;
        for (int k = 12; k >= 6; k--) if (l <= (1 << k)) n = k;
        return n;
    endfunction

    function automatic int rev5(input int v);
        int r = 0;
        for (int b = 0; b < 5; b++) if (v[b]) r |= (1 << (4 - b));
        return r;
    endfunction

    // reference per R4, R5, R6, R7
    function automatic int build_ref(input int l);
        int n = mother_log(l);
        int k = 1 << (n - 5);
        int cnt = 0;
        for (int j = 0; j < k; j++) begin
            for (int i = 0; i < 32; i++) begin
                int c = (2 * ((13 * i + 5) % 64) + 1) % k;
                int a = rev5(i) * k + ((j * c) % k);
                if (a < l) begin
                    exp_addr[cnt] = a;
                    cnt++;
                end
            end
        end
        return cnt;
    endfunction

    task automatic run_job(input int l, input bit poke);
        int  n_exp = build_ref(l);
        int  m = 1 << mother_log(l);
        int  got = 0;
        int  waits = 0;
        int  bad_seq = 0;
        int  first_bad_act = 0;
        int  first_bad_exp = 0;
        int  dup = 0;
        bit  got_done = 0;
        for (int q = 0; q < 4096; q++) seen[q] = 0;
        @(negedge clk);
        start  = 1'b1;
        len_in = 13'(l);
        @(negedge clk);
        start  = 1'b0;
        len_in = '0;
        waits  = 1;
        check(ready == 1'b0, "R2", int'(ready), 0);
        while (!got_done && waits < 5000) begin
            if (poke && waits == 10) begin
                start  = 1'b1;
                len_in = 13'd77;
            end else begin
                start  = 1'b0;
            end
            @(negedge clk);
            waits++;
            if (addr_valid) begin
                if (got < n_exp && int'(addr_out) != exp_addr[got] && bad_seq == 0) begin
                    first_bad_act = int'(addr_out);
                    first_bad_exp = exp_addr[got];
                    bad_seq = 1;
                end
                if (int'(addr_out) < 4096) begin
                    if (seen[addr_out]) dup++;
                    seen[addr_out] = 1;
                end
                got++;
            end
            if (done) begin
                got_done = 1;
                check(ready == 1'b1, "R9 ready with done", int'(ready), 1);
            end
        end
        start = 1'b0;
        check(n_exp == l, "R8 reference count", n_exp, l);
        check(got == l, "R8 valid count", got, l);
        check(bad_seq == 0, "R6 order", first_bad_act, first_bad_exp);
        check(dup == 0, "R8 no duplicates", dup, 0);
        check(waits == m + 2, "R9 job length", waits, m + 2);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        check(addr_valid == 1'b0, "R7 quiet after job", int'(addr_valid), 0);
    endtask

    task automatic try_bad(input int l);
        int hits = 0;
        @(negedge clk);
        start  = 1'b1;
        len_in = 13'(l);
        @(negedge clk);
        start  = 1'b0;
        len_in = '0;
        for (int t = 0; t < 6; t++) begin
            if (!ready || addr_valid || done) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R3 illegal length ignored", hits, 0);
    endtask

    initial begin
        int lens [14] = '{1, 33, 63, 64, 65, 100, 128, 129, 500, 1000, 2048, 2049, 3000, 4096};
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && addr_valid == 1'b0 && done == 1'b0, "R1 reset state",
              int'({ready, addr_valid, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);

        try_bad(0);
        try_bad(4097);
        try_bad(8191);

        foreach (lens[x]) run_job(lens[x], 1'b0);

        // R10: mid-run start must not disturb the job
        run_job(300, 1'b1);
        run_job(77, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule